// File: doc/BRIEF.md
# Four-Port Cut-Through Word Switch

This block connects four 32-bit word links. Every link is a pair of one-way channels, each using valid/ready handshaking. Traffic is made of packets. A packet opens with one header word that names the target, the sender and the number of payload words that follow. When an input holds a header, the switch maps the destination identifier to an output through a fixed table. Once that output is free it is locked to the input. The remaining words are then passed through one at a time as they arrive. The switch never collects a whole packet first.

Each input owns a single word register and nothing more. When the chosen output is not ready, that register stays full and its input's ready drops. The stall reaches back to the sender word by word, so no word is ever dropped. Packets bound for different outputs move in the same cycles. When several inputs want the same idle output, the lowest-numbered one wins. The others keep their header word and wait.

Each input runs a two-state machine. EXPECT_HDR moves to EXPECT_PAY when a header with a non-zero length is accepted, and stays put for a zero-length header. EXPECT_PAY returns to EXPECT_HDR when the last payload word is accepted. Each output runs a three-state machine. IDLE moves to HEAD when any header requests it, and the winner is latched as owner. HEAD returns to IDLE when a zero-length header is taken, and otherwise moves to BODY with the length loaded into a counter. BODY counts accepted words down and returns to IDLE on the last one.

Top module: `pktsw_top`

## Requirements
- R1: A header word carries the destination identifier in bits 31:24, the source identifier in bits 23:16, and the payload word count in bits 15:0. The fixed route table sends destination identifier d to output d modulo 4, which is its two low bits. For example, identifier 7 goes to output 3.
- R2: While reset is held and after it is released, with no traffic, every out_valid bit is low and every in_ready bit is high.
- R3: Each input stores at most one word. Its in_ready is high when that register is empty, or when the stored word leaves in the same cycle. A stored word that cannot leave is kept unchanged, and in_ready stays low.
- R4: From its header until the last of the announced payload words, an output carries the words of one packet only. They arrive unchanged and in their original order. Every word that enters is delivered exactly once.
- R5: Whenever out_valid is high while out_ready is low, out_valid is still high in the next cycle and out_data has not changed.
- R6: When an idle output sees headers from several inputs in the same cycle, the lowest-numbered input is granted first. The others keep their headers and are granted later in ascending order.
- R7: Packets headed for different outputs are forwarded in the same clock cycles. Each input is served by at most one output per cycle.
- R8: A header whose length field is zero is a complete packet. The output is released right after that header is accepted, and the next word from the same input is treated as a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-input word offered |
| in_data | input | 4x32 | Per-input word |
| in_ready | output | 4 | Per-input word taken this cycle when valid |
| out_valid | output | 4 | Per-output word offered |
| out_data | output | 4x32 | Per-output word |
| out_ready | input | 4 | Per-output downstream can take a word |

## Verification
The assertions assume that every packet is well formed: the length in each header must equal the number of payload words the sender actually supplies. If it does not, the input-side and output-side counters lose agreement on where packets start. The stimulus guarantees this by building every packet through one task, which writes the header length from the payload count it appends. Downstream ready is left free: it is driven with fixed patterns, rotating stalls and a full block. Senders pause in a rotating gap pattern, but only between words they have not yet offered.

// File: rtl/pktsw_pkg.sv
package pktsw_pkg;

    // Header field layout shared by ingress and egress logic
    localparam int HDR_DST_LSB = 24;
    localparam int HDR_SRC_LSB = 16;
    localparam int HDR_LEN_W   = 16;

    // Ingress: kind of the next word to be accepted on the link
    typedef enum logic {
        IN_EXPECT_HDR,
        IN_EXPECT_PAY
    } in_state_e;

    // Egress: lock state of one output
    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_HEAD,
        OUT_BODY
    } out_state_e;

endpackage

// File: rtl/pktsw_ingress.sv
module pktsw_ingress
    import pktsw_pkg::*;
#(
    parameter int W       = 32,
    parameter int NP      = 4,
    parameter int LEN_W   = HDR_LEN_W,
    parameter int DST_LSB = HDR_DST_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    output logic          in_ready,
    input  logic          pop,
    output logic          hold_vld,
    output logic [W-1:0]  hold_data,
    output logic [NP-1:0] req_oh
);
    localparam int PW = $clog2(NP);

    in_state_e        state_q, state_d;
    logic [LEN_W-1:0] left_q, left_d;
    logic             head_q;
    logic             take;
    logic [LEN_W-1:0] hdr_len;
    logic [PW-1:0]    dst_port;

    always_comb begin
        in_ready = !hold_vld || pop;
        take     = in_valid && in_ready;
        hdr_len  = in_data[LEN_W-1:0];
    end

    // Next-state logic: tracks packet boundaries on the incoming link
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (take) begin
            unique case (state_q)
                IN_EXPECT_HDR: begin
                    left_d  = hdr_len;
                    state_d = (hdr_len != '0) ? IN_EXPECT_PAY : IN_EXPECT_HDR;
                end
                IN_EXPECT_PAY: begin
                    left_d = left_q - LEN_W'(1);
                    if (left_q == LEN_W'(1)) begin
                        state_d = IN_EXPECT_HDR;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IN_EXPECT_HDR;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // Word register with its header tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_data <= '0;
            head_q    <= 1'b0;
        end else if (take) begin
            hold_vld  <= 1'b1;
            hold_data <= in_data;
            head_q    <= (state_q == IN_EXPECT_HDR);
        end else if (pop) begin
            hold_vld  <= 1'b0;
        end
    end

    // Fixed route table: destination id modulo port count
    assign dst_port = hold_data[DST_LSB +: PW];

    generate
        for (genvar o = 0; o < NP; o++) begin : g_req
            assign req_oh[o] = hold_vld && head_q && (dst_port == PW'(o));
        end
    endgenerate

    // R3
    held_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !pop) |=> (hold_vld && $stable(hold_data)));

endmodule

// File: rtl/pktsw_egress.sv
module pktsw_egress
    import pktsw_pkg::*;
#(
    parameter int W     = 32,
    parameter int NP    = 4,
    parameter int LEN_W = HDR_LEN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0]         req,
    input  logic [NP-1:0]         hold_vld,
    input  logic [NP-1:0][W-1:0]  hold_data,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [W-1:0]          out_data,
    output logic [NP-1:0]         take_oh
);
    localparam int PW = $clog2(NP);

    out_state_e       state_q, state_d;
    logic [PW-1:0]    owner_q, owner_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [PW-1:0]    win;
    logic             fire;
    logic [LEN_W-1:0] hdr_len;

    // Fixed priority: lowest index written last wins
    always_comb begin
        win = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = PW'(i);
            end
        end
    end

    // Output process
    always_comb begin
        out_valid = (state_q != OUT_IDLE) && hold_vld[owner_q];
        out_data  = hold_data[owner_q];
        fire      = out_valid && out_ready;
        take_oh   = fire ? (NP'(1) << owner_q) : '0;
        hdr_len   = out_data[LEN_W-1:0];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OUT_IDLE: begin
                if (|req) begin
                    state_d = OUT_HEAD;
                    owner_d = win;
                end
            end
            OUT_HEAD: begin
                if (fire) begin
                    if (hdr_len == '0) begin
                        state_d = OUT_IDLE;
                    end else begin
                        cnt_d   = hdr_len;
                        state_d = OUT_BODY;
                    end
                end
            end
            OUT_BODY: begin
                if (fire) begin
                    cnt_d = cnt_q - LEN_W'(1);
                    if (cnt_q == LEN_W'(1)) begin
                        state_d = OUT_IDLE;
                    end
                end
            end
            default: state_d = OUT_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            owner_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            cnt_q   <= cnt_d;
        end
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6
    top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_IDLE && req[0]) |=> (state_q == OUT_HEAD && owner_q == '0));

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_BODY) |=> (state_q == OUT_IDLE || $stable(owner_q)));

    // R8
    empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_HEAD && fire && hdr_len == '0) |=> (state_q == OUT_IDLE));

endmodule

// File: rtl/pktsw_top.sv
module pktsw_top
    import pktsw_pkg::*;
#(
    parameter int NP      = 4,
    parameter int W       = 32,
    parameter int LEN_W   = HDR_LEN_W,
    parameter int DST_LSB = HDR_DST_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        in_valid,
    input  logic [NP-1:0][W-1:0] in_data,
    output logic [NP-1:0]        in_ready,
    output logic [NP-1:0]        out_valid,
    output logic [NP-1:0][W-1:0] out_data,
    input  logic [NP-1:0]        out_ready
);
    logic [NP-1:0]          hold_vld;
    logic [NP-1:0][W-1:0]   hold_data;
    logic [NP-1:0][NP-1:0]  req_m;   // [input][output]
    logic [NP-1:0][NP-1:0]  req_t;   // [output][input]
    logic [NP-1:0][NP-1:0]  take_m;  // [output][input]
    logic [NP-1:0][NP-1:0]  take_t;  // [input][output]
    logic [NP-1:0]          pop;

    generate
        for (genvar i = 0; i < NP; i++) begin : g_in
            pktsw_ingress #(
                .W(W), .NP(NP), .LEN_W(LEN_W), .DST_LSB(DST_LSB)
            ) u_in (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (in_valid[i]),
                .in_data  (in_data[i]),
                .in_ready (in_ready[i]),
                .pop      (pop[i]),
                .hold_vld (hold_vld[i]),
                .hold_data(hold_data[i]),
                .req_oh   (req_m[i])
            );

            for (genvar o = 0; o < NP; o++) begin : g_x
                assign req_t[o][i]  = req_m[i][o];
                assign take_t[i][o] = take_m[o][i];
            end

            assign pop[i] = |take_t[i];

            // R7
            single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(take_t[i]));
        end

        for (genvar o = 0; o < NP; o++) begin : g_out
            pktsw_egress #(
                .W(W), .NP(NP), .LEN_W(LEN_W)
            ) u_out (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (req_t[o]),
                .hold_vld (hold_vld),
                .hold_data(hold_data),
                .out_ready(out_ready[o]),
                .out_valid(out_valid[o]),
                .out_data (out_data[o]),
                .take_oh  (take_m[o])
            );
        end
    endgenerate

endmodule

// File: tb/test_pktsw_top.sv
`timescale 1ns/1ps
module test_pktsw_top;
    localparam int NP = 4;
    localparam int WD = 150000;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NP-1:0]         in_valid;
    logic [NP-1:0][31:0]   in_data;
    logic [NP-1:0]         in_ready;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0][31:0]   out_data;
    logic [NP-1:0]         out_ready;

    pktsw_top i_pktsw_top (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit gap_on = 0, stall_on = 0, block_all = 0, both01 = 0;
    bit acc [NP];
    bit hold_seen [NP];
    logic [31:0] hold_val [NP];
    logic [31:0] srcq [NP][$];
    logic [31:0] expq [NP][NP][$];
    int hdr_log [NP][$];
    int cur_src [NP];
    int rem [NP];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic send_pkt(input int src, input int dst, input int len, input int tag);
        logic [31:0] w;
        w = {8'(dst), 8'(src), 16'(len)};
        srcq[src].push_back(w);
        expq[src][dst % NP].push_back(w);
        for (int k = 0; k < len; k++) begin
            w = {8'(tag), 8'(src), 16'(k + 1)};
            srcq[src].push_back(w);
            expq[src][dst % NP].push_back(w);
        end
    endtask

    // Reference model of one output: per-source packet queues
    task automatic out_word(input int o, input logic [31:0] w);
        int s;
        if (rem[o] < 0) begin
            s = int'(w[23:16]);
            hdr_log[o].push_back(s);
            check(int'(w[25:24]) == o, "R1 route", 32'(w[25:24]), 32'(o));
            if (s >= NP || expq[s][o].size() == 0) begin
                check(0, "R4 unexpected header", w, 32'hFFFF_FFFF);
            end else begin
                check(w == expq[s][o][0], "R4 header", w, expq[s][o][0]);
                void'(expq[s][o].pop_front());
                cur_src[o] = s;
                rem[o] = (w[15:0] == 16'd0) ? -1 : int'(w[15:0]);
            end
        end else begin
            s = cur_src[o];
            if (expq[s][o].size() == 0) begin
                check(0, "R4 extra word", w, 32'hFFFF_FFFF);
            end else begin
                check(w == expq[s][o][0], "R4 payload", w, expq[s][o][0]);
                void'(expq[s][o].pop_front());
            end
            rem[o] = rem[o] - 1;
            if (rem[o] == 0) rem[o] = -1;
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > WD) begin
            check(0, "watchdog", 32'(cyc), 32'(WD));
            finish_run();
        end
        for (int o = 0; o < NP; o++)
            out_ready[o] = block_all ? 1'b0 : (stall_on ? ((cyc + o) % 3 != 0) : 1'b1);
        for (int i = 0; i < NP; i++) begin
            if (acc[i]) in_valid[i] = 1'b0;
            acc[i] = 0;
            if (!in_valid[i] && srcq[i].size() > 0 && (!gap_on || ((cyc + i) % 4 != 0))) begin
                in_valid[i] = 1'b1;
                in_data[i]  = srcq[i][0];
            end
        end
        #2;
        for (int i = 0; i < NP; i++) begin
            if (in_valid[i] && in_ready[i]) begin
                void'(srcq[i].pop_front());
                acc[i] = 1;
            end
        end
        for (int o = 0; o < NP; o++) begin
            if (hold_seen[o])
                check(out_valid[o] && out_data[o] == hold_val[o], "R5 stall hold", out_data[o], hold_val[o]);
            hold_seen[o] = out_valid[o] && !out_ready[o];
            hold_val[o]  = out_data[o];
            if (out_valid[o] && out_ready[o]) out_word(o, out_data[o]);
        end
        if (out_valid[0] && out_valid[1]) both01 = 1;
    endtask

    function automatic bit all_idle();
        for (int i = 0; i < NP; i++) begin
            if (srcq[i].size() != 0 || in_valid[i] || out_valid[i] || rem[i] >= 0) return 0;
            for (int o = 0; o < NP; o++) if (expq[i][o].size() != 0) return 0;
        end
        return 1;
    endfunction

    task automatic drain(input string tag);
        for (int k = 0; k < 5000; k++) begin
            step();
            if (all_idle()) break;
        end
        check(all_idle(), tag, 32'(all_idle()), 32'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = '0;
        in_data = '0;
        out_ready = '1;
        for (int o = 0; o < NP; o++) begin
            rem[o] = -1;
            cur_src[o] = 0;
            acc[o] = 0;
            hold_seen[o] = 0;
        end
        repeat (3) @(negedge clk);
        #2;
        check(out_valid == '0, "R2 valid in reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        step();
        check(out_valid == '0, "R2 valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == '1, "R2 ready after reset", 32'(in_ready), 32'hF);

        // R1 R4: single packet
        send_pkt(0, 2, 3, 8'h11);
        drain("R4 single packet delivered");

        // R7: four concurrent flows on distinct outputs
        both01 = 0;
        send_pkt(0, 1, 5, 8'h21);
        send_pkt(1, 0, 5, 8'h22);
        send_pkt(2, 3, 4, 8'h23);
        send_pkt(3, 2, 2, 8'h24);
        drain("R7 concurrent drain");
        check(both01, "R7 outputs 0 and 1 active together", 32'(both01), 32'd1);

        // R6: three inputs contend for output 0
        hdr_log[0].delete();
        send_pkt(2, 0, 2, 8'h31);
        send_pkt(1, 0, 2, 8'h32);
        send_pkt(3, 4, 1, 8'h33);
        drain("R6 contention drain");
        check(hdr_log[0].size() == 3, "R6 header count", 32'(hdr_log[0].size()), 32'd3);
        if (hdr_log[0].size() == 3) begin
            check(hdr_log[0][0] == 1, "R6 first grant", 32'(hdr_log[0][0]), 32'd1);
            check(hdr_log[0][1] == 2, "R6 second grant", 32'(hdr_log[0][1]), 32'd2);
            check(hdr_log[0][2] == 3, "R6 third grant", 32'(hdr_log[0][2]), 32'd3);
        end

        // R8: zero-length packets, route table id 7 -> output 3
        hdr_log[3].delete();
        send_pkt(0, 7, 0, 8'h41);
        send_pkt(0, 3, 2, 8'h42);
        send_pkt(1, 3, 0, 8'h43);
        drain("R8 zero-length drain");
        check(hdr_log[3].size() == 3, "R8 headers seen", 32'(hdr_log[3].size()), 32'd3);

        // R3: blocked output fills the input register only
        block_all = 1;
        send_pkt(0, 2, 3, 8'h51);
        repeat (6) step();
        check(in_ready[0] == 1'b0, "R3 ready low while held", 32'(in_ready[0]), 32'd0);
        check(srcq[0].size() == 3, "R3 one word stored", 32'(srcq[0].size()), 32'd3);
        check(out_valid[2] == 1'b1, "R3 held header offered", 32'(out_valid[2]), 32'd1);
        check(out_data[2] == {8'd2, 8'd0, 16'd3}, "R3 held header value", out_data[2], {8'd2, 8'd0, 16'd3});
        block_all = 0;
        drain("R3 blocked drain");

        // R4 R5: stress with stalls and gaps
        gap_on = 1;
        stall_on = 1;
        for (int r = 0; r < 6; r++)
            for (int i = 0; i < NP; i++)
                send_pkt(i, (i * 3 + r) % 8, (r * 5 + i) % 7, r * 16 + i);
        drain("R4 stress drain");
        gap_on = 0;
        stall_on = 0;

        finish_run();
    end
endmodule